// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block collects thirty-two interrupt sources and assigns each one a 3-bit priority through three level-configuration registers. Some level fields are shared by a group of sources. The controller keeps an in-service bitmap with one bit per priority level. A pending source is offered to the processor only when its level is strictly above the highest level currently in service, so a higher-priority interrupt can preempt one that is still being handled.

Software reads the number register to learn which source to serve. That read marks the source's level as in service. When the handler finishes, a write of any value to the retire register drops the most significant in-service level. Software can also clear in-service bits directly through a write-one-to-clear register. A software request register lets software raise any source without its hardware line.

All registers sit behind a single-cycle register port. Writes and read side effects take effect at the clock edge. Read data is combinational from the address.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset, every level field is 0, the software request register is 0, the in-service bitmap is 0, `irq` is low and the number register (address 4) reads 32.
- R2: Level fields sit in three registers, each field 3 bits wide.
  - Address 0: source 0 at bits [2:0]; sources 1-3 share [6:4]; sources 4-5 share [10:8]; sources 6-7 share [14:12].
  - Address 1: source 8+k at bits [4k+2:4k], for k = 0..7.
  - Address 2: sources 16+2k and 17+2k share bits [4k+2:4k], for k = 0..7.
- R3: A source whose level is 0 is never presented and never raises `irq`.
- R4: Among eligible pending sources, the one with the highest level wins. On a tie of level, the lowest source number wins.
- R5: `irq` is high exactly when an eligible source exists. Address 4 reads the winning source number, or 32 when there is none.
- R6: A read of address 4 that returns a source number sets the in-service bit indexed by that source's level. A read that returns 32 leaves the bitmap unchanged.
- R7: A pending source is eligible only if its level is strictly greater than the index of the highest set in-service bit (0 when the bitmap is empty).
- R8: A write of any value to address 6 clears the most significant set in-service bit. On an empty bitmap it has no effect.
- R9: Writing address 5 clears each in-service bit 1..7 whose data bit is 1. Data bit 0 is ignored. Writing 0xFE empties the bitmap. Address 5 reads the bitmap in bits [7:0].
- R10: Address 3 holds software request bits, one per source, ORed with the hardware requests. Writing 0 cancels all software requests.
- R11: Hardware request lines are sampled into a pending register, so a change on `src_req` reaches `irq` one clock edge later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | 32 | Hardware request lines, one per source |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect on address 4) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq | output | 1 | Interrupt request to the processor |

## Verification
Arbitration is exercised with the following patterns:
- A single request on each field group. This separates correct field decoding from a shifted or crossed field.
- Two requests at different levels. This separates a priority comparison from a plain index search.
- Two requests sharing one level. This exposes a reversed tie-break.
- A request at or below the current in-service level and one strictly above it. This distinguishes a strict from a non-strict nesting comparison.

The retire and direct-clear writes are applied to bitmaps with two bits set, so that clearing the wrong bit or clearing all bits shows up. The software request path and the one-cycle sampling of `src_req` are compared each clock against a behavioural model.

// File: rtl/nic_pkg.sv
package nic_pkg;
    localparam int NSRC  = 32;
    localparam int LVLW  = 3;
    localparam int NLVL  = 1 << LVLW;
    localparam int NUMW  = $clog2(NSRC) + 1;
    localparam int DATAW = 32;
    localparam int ADDRW = 3;
    localparam int FLDST = 4;            // stride between level fields

    typedef logic [LVLW-1:0] lvl_t;

    typedef struct packed {
        logic            valid;
        logic [NUMW-1:0] num;
        lvl_t            lvl;
    } win_t;

    typedef enum logic [ADDRW-1:0] {
        A_LVL_LO  = 3'd0,
        A_LVL_MID = 3'd1,
        A_LVL_HI  = 3'd2,
        A_SOFT    = 3'd3,
        A_NUM     = 3'd4,
        A_CUR     = 3'd5,
        A_RETIRE  = 3'd6
    } addr_e;

    // index of the most significant set bit above bit 0, else 0
    function automatic lvl_t top_level(input logic [NLVL-1:0] m);
        lvl_t t;
        t = '0;
        for (int l = 1; l < NLVL; l++)
            if (m[l]) t = lvl_t'(l);
        return t;
    endfunction
endpackage

// File: rtl/nic_level_map.sv
module nic_level_map
    import nic_pkg::*;
(
    input  logic [DATAW-1:0]     cfg_lo,
    input  logic [DATAW-1:0]     cfg_mid,
    input  logic [DATAW-1:0]     cfg_hi,
    output logic [NSRC*LVLW-1:0] lvl_flat
);
    logic unused_cfg;
    assign unused_cfg = ^{cfg_lo, cfg_mid, cfg_hi};

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        if (i == 0) begin : g_f0
            assign lvl_flat[i*LVLW +: LVLW] = cfg_lo[0 +: LVLW];
        end else if (i < 4) begin : g_f1
            assign lvl_flat[i*LVLW +: LVLW] = cfg_lo[1*FLDST +: LVLW];
        end else if (i < 6) begin : g_f2
            assign lvl_flat[i*LVLW +: LVLW] = cfg_lo[2*FLDST +: LVLW];
        end else if (i < 8) begin : g_f3
            assign lvl_flat[i*LVLW +: LVLW] = cfg_lo[3*FLDST +: LVLW];
        end else if (i < 16) begin : g_mid
            assign lvl_flat[i*LVLW +: LVLW] = cfg_mid[(i-8)*FLDST +: LVLW];
        end else begin : g_hi
            assign lvl_flat[i*LVLW +: LVLW] = cfg_hi[((i-16)/2)*FLDST +: LVLW];
        end
    end
endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter
    import nic_pkg::*;
(
    input  logic [NSRC-1:0]      pend,
    input  logic [NSRC*LVLW-1:0] lvl_flat,
    input  lvl_t                 ceiling,
    output win_t                 win
);
    always_comb begin
        win = '0;
        // descending scan with >= keeps the lowest index on a level tie
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend[i] && (lvl_flat[i*LVLW +: LVLW] > ceiling) &&
                (lvl_flat[i*LVLW +: LVLW] >= win.lvl)) begin
                win.valid = 1'b1;
                win.num   = NUMW'(i);
                win.lvl   = lvl_flat[i*LVLW +: LVLW];
            end
        end
    end
endmodule

// File: rtl/nic_inservice.sv
module nic_inservice
    import nic_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            set_en,
    input  lvl_t            set_lvl,
    input  logic            retire,
    input  logic            clr_en,
    input  logic [NLVL-1:0] clr_mask,
    output logic [NLVL-1:0] cur,
    output lvl_t            ceiling
);
    logic [NLVL-1:0] nxt;

    assign ceiling = top_level(cur);

    always_comb begin
        nxt = cur;
        if (set_en) nxt[set_lvl] = 1'b1;
        if (retire && ceiling != '0) nxt[ceiling] = 1'b0;
        if (clr_en) nxt = nxt & ~{clr_mask[NLVL-1:1], 1'b0};
        nxt[0] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= nxt;
    end

    p_retire_one_r8: assert property (@(posedge clk) disable iff (rst)
        (retire && !set_en && !clr_en && cur != '0)
        |=> $countones(cur) == $countones($past(cur)) - 1);

    p_retire_top_r8: assert property (@(posedge clk) disable iff (rst)
        (retire && !set_en && !clr_en && cur != '0) |=> !cur[$past(ceiling)]);

    p_set_bit_r6: assert property (@(posedge clk) disable iff (rst)
        (set_en && set_lvl != '0 && !retire && !clr_en) |=> cur[$past(set_lvl)]);

    p_clr_bits_r9: assert property (@(posedge clk) disable iff (rst)
        (clr_en && !set_en && !retire)
        |=> (cur & $past(clr_mask) & {{(NLVL-1){1'b1}}, 1'b0}) == '0);
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
    import nic_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NSRC-1:0]  src_req,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [ADDRW-1:0] reg_addr,
    input  logic [DATAW-1:0] reg_wdata,
    output logic [DATAW-1:0] reg_rdata,
    output logic             irq
);
    logic [DATAW-1:0]     cfg_lo, cfg_mid, cfg_hi;
    logic [NSRC-1:0]      soft_q, pend_q;
    logic [NSRC*LVLW-1:0] lvl_flat;
    logic [NLVL-1:0]      cur;
    lvl_t                 ceiling;
    win_t                 win;
    logic [NUMW-1:0]      num_rd;
    addr_e                addr;

    assign addr = addr_e'(reg_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_lo  <= '0;
            cfg_mid <= '0;
            cfg_hi  <= '0;
            soft_q  <= '0;
            pend_q  <= '0;
        end else begin
            pend_q <= src_req;
            if (reg_wr) begin
                case (addr)
                    A_LVL_LO:  cfg_lo  <= reg_wdata;
                    A_LVL_MID: cfg_mid <= reg_wdata;
                    A_LVL_HI:  cfg_hi  <= reg_wdata;
                    A_SOFT:    soft_q  <= reg_wdata[NSRC-1:0];
                    default:   ;
                endcase
            end
        end
    end

    nic_level_map u_map (
        .cfg_lo  (cfg_lo),
        .cfg_mid (cfg_mid),
        .cfg_hi  (cfg_hi),
        .lvl_flat(lvl_flat)
    );

    nic_arbiter u_arb (
        .pend    (pend_q | soft_q),
        .lvl_flat(lvl_flat),
        .ceiling (ceiling),
        .win     (win)
    );

    nic_inservice u_isr (
        .clk     (clk),
        .rst     (rst),
        .set_en  (reg_rd && addr == A_NUM && win.valid),
        .set_lvl (win.lvl),
        .retire  (reg_wr && addr == A_RETIRE),
        .clr_en  (reg_wr && addr == A_CUR),
        .clr_mask(reg_wdata[NLVL-1:0]),
        .cur     (cur),
        .ceiling (ceiling)
    );

    assign irq    = win.valid;
    assign num_rd = win.valid ? win.num : NUMW'(NSRC);

    always_comb begin
        case (addr)
            A_LVL_LO:  reg_rdata = cfg_lo;
            A_LVL_MID: reg_rdata = cfg_mid;
            A_LVL_HI:  reg_rdata = cfg_hi;
            A_SOFT:    reg_rdata = DATAW'(soft_q);
            A_NUM:     reg_rdata = DATAW'(num_rd);
            A_CUR:     reg_rdata = DATAW'(cur);
            default:   reg_rdata = '0;
        endcase
    end

    p_above_ceiling_r7: assert property (@(posedge clk) disable iff (rst)
        irq |-> win.lvl > ceiling);

    p_never_masked_r3: assert property (@(posedge clk) disable iff (rst)
        irq |-> win.lvl != '0);

    p_idle_number_r5: assert property (@(posedge clk) disable iff (rst)
        !irq |-> num_rd == NUMW'(NSRC));

    p_empty_read_keeps_r6: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && addr == A_NUM && !irq && !reg_wr) |=> $stable(cur));
endmodule

// File: tb/nest_irq_ctrl_tb.sv
`timescale 1ns/1ps
module nest_irq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] src_req = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    always #2.5 clk = ~clk;

    nest_irq_ctrl u_dut (
        .clk(clk), .rst(rst), .src_req(src_req), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    // behavioural reference state
    logic [31:0] m_lo = '0, m_mid = '0, m_hi = '0, m_soft = '0, m_pend = '0;
    logic [7:0]  m_cur = '0;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    function automatic int m_lvl(int i);
        if (i == 0)       return int'(m_lo[2:0]);
        else if (i <= 3)  return int'(m_lo[6:4]);
        else if (i <= 5)  return int'(m_lo[10:8]);
        else if (i <= 7)  return int'(m_lo[14:12]);
        else if (i <= 15) return int'(m_mid[4*(i-8) +: 3]);
        else              return int'(m_hi[4*((i-16)/2) +: 3]);
    endfunction

    function automatic int m_top();
        for (int l = 7; l >= 1; l--) if (m_cur[l]) return l;
        return 0;
    endfunction

    function automatic int m_win();
        int best = 32, bl = 0;
        logic [31:0] p = m_pend | m_soft;
        for (int i = 0; i < 32; i++)
            if (p[i] && m_lvl(i) > m_top() && m_lvl(i) > bl) begin
                bl = m_lvl(i);
                best = i;
            end
        return best;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // one clock: advance the model with the driven inputs, compare irq
    task automatic step();
        logic [31:0] n_lo = m_lo, n_mid = m_mid, n_hi = m_hi, n_soft = m_soft;
        logic [7:0]  n_cur = m_cur;
        int w = m_win();
        int t = m_top();
        if (reg_rd && reg_addr == 3'd4 && w < 32) n_cur[m_lvl(w)] = 1'b1;
        if (reg_wr) begin
            case (reg_addr)
                3'd0: n_lo = reg_wdata;
                3'd1: n_mid = reg_wdata;
                3'd2: n_hi = reg_wdata;
                3'd3: n_soft = reg_wdata;
                3'd5: n_cur = n_cur & ~(reg_wdata[7:0] & 8'hFE);
                3'd6: if (t != 0) n_cur[t] = 1'b0;
                default: ;
            endcase
        end
        @(posedge clk);
        #1;
        m_pend = src_req; m_lo = n_lo; m_mid = n_mid; m_hi = n_hi;
        m_soft = n_soft; m_cur = n_cur;
        check("R5 irq vs model", {31'd0, irq}, {31'd0, m_win() != 32});
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic rd_num(string req, int exp);
        reg_addr = 3'd4; reg_rd = 1'b1;
        #1 check(req, reg_rdata, exp);
        step();
        reg_rd = 1'b0;
    endtask

    task automatic peek(string req, logic [2:0] a, logic [31:0] exp);
        reg_addr = a;
        #1 check(req, reg_rdata, exp);
    endtask

    task automatic set_req(logic [31:0] v);
        src_req = v;
        step();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset state
        peek("R1 number", 3'd4, 32);
        peek("R1 inservice", 3'd5, 0);
        peek("R1 soft", 3'd3, 0);
        check("R1 irq", {31'd0, irq}, 0);
        // R3 all requests at level 0
        set_req(32'hFFFF_FFFF);
        step();
        check("R3 masked irq", {31'd0, irq}, 0);
        peek("R3 masked number", 3'd4, 32);
        // R2 field layout
        wr(3'd0, 32'h0000_0030);
        set_req(32'h0000_0004); step();
        peek("R2 src2 via shared field", 3'd4, 2);
        set_req(32'h0000_0001); step();
        check("R3 src0 level0", {31'd0, irq}, 0);
        wr(3'd0, 32'h0000_0530);
        set_req(32'h0000_0024); step();
        peek("R4 higher level wins", 3'd4, 5);
        wr(3'd1, 32'h0000_0040);
        set_req(32'h0000_0200); step();
        peek("R2 src9 field", 3'd4, 9);
        wr(3'd2, 32'h0000_0002);
        set_req(32'h0002_0000); step();
        peek("R2 src17 pair field", 3'd4, 17);
        set_req(32'h0003_0000); step();
        peek("R4 tie lowest index", 3'd4, 16);
        wr(3'd1, 32'h0000_0404);
        set_req(32'h0002_0500); step();
        peek("R4 tie src8 src10", 3'd4, 8);
        wr(3'd1, 32'h0006_0404);
        set_req(32'h0002_1500); step();
        peek("R4 level6 wins", 3'd4, 12);
        // R6 / R7 nesting
        rd_num("R6 read returns", 12);
        peek("R6 bit6 set", 3'd5, 32'h40);
        peek("R7 nothing above 6", 3'd4, 32);
        check("R7 irq low", {31'd0, irq}, 0);
        rd_num("R6 empty read", 32);
        peek("R6 bitmap unchanged", 3'd5, 32'h40);
        wr(3'd1, 32'h0076_0404);
        set_req(32'h0002_3500); step();
        peek("R7 level7 preempts", 3'd4, 13);
        rd_num("R6 nested read", 13);
        peek("R6 two bits", 3'd5, 32'hC0);
        // R8 retire
        wr(3'd6, 32'h0);
        peek("R8 top bit cleared", 3'd5, 32'h40);
        peek("R8 level7 eligible again", 3'd4, 13);
        wr(3'd6, 32'h7B);
        peek("R8 second retire", 3'd5, 0);
        wr(3'd6, 32'h0);
        peek("R8 empty retire", 3'd5, 0);
        // R9 direct clear
        set_req(32'h0002_1500); step();
        rd_num("R9 setup level6", 12);
        set_req(32'h0002_3500); step();
        rd_num("R9 setup level7", 13);
        peek("R9 setup bitmap", 3'd5, 32'hC0);
        wr(3'd5, 32'h01);
        peek("R9 bit0 ignored", 3'd5, 32'hC0);
        wr(3'd5, 32'h40);
        peek("R9 bit6 cleared", 3'd5, 32'h80);
        wr(3'd5, 32'hFE);
        peek("R9 all cleared", 3'd5, 0);
        // R10 software requests
        set_req(32'h0); step();
        wr(3'd2, 32'h0000_0300);
        wr(3'd3, 32'h0010_0000);
        peek("R10 soft request", 3'd4, 20);
        check("R10 soft irq", {31'd0, irq}, 1);
        wr(3'd3, 32'h0);
        peek("R10 cancel", 3'd4, 32);
        check("R10 cancel irq", {31'd0, irq}, 0);
        // R11 one-cycle sampling
        src_req = 32'h0020_0000;
        #1 check("R11 before edge", {31'd0, irq}, 0);
        step();
        check("R11 after edge", {31'd0, irq}, 1);
        peek("R11 number", 3'd4, 21);
        // R3 all levels cleared again
        wr(3'd0, 32'h0); wr(3'd1, 32'h0); wr(3'd2, 32'h0);
        set_req(32'hFFFF_FFFF); step();
        check("R3 zero levels", {31'd0, irq}, 0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule